// File: doc/BRIEF.md
# Bit-Manipulation Execute Slice

This block is a 64-bit execute slice for bit-manipulation operations. It covers single-bit edits and extraction, shifts that fill with ones, scaled address addition, operand packing, and 32-bit word forms of bit counting and rotation. It also reverses the byte order of a full register. The caller presents two source operands, an operation code and a strobe. The result comes back from a register one clock later, together with a valid flag and an illegal-operation flag.

Operands arrive already decoded. The slice does not look at instruction bits. The register width is the parameter `XLEN`. The word forms always work on the low 32 bits. A word form that returns a count zero-extends it, and a word form that returns a rotated value sign-extends it from bit 31. A full-width operation takes its shift amount from the low log2(`XLEN`) bits of the second operand. A word rotate takes only the low 5 bits.

Top module: `bm_alu`

## Requirements
- R1: Op 0 sets, op 1 clears and op 2 inverts the bit of rs1 selected by rs2[5:0]. The upper bits of rs2 are ignored.
- R2: Op 3 returns bit rs2[5:0] of rs1 in bit 0 of the result. All other result bits are zero.
- R3: Op 4 shifts rs1 left by rs2[5:0] and fills the vacated bits with ones. Op 5 does the same to the right.
- R4: Ops 6, 7 and 8 return (rs1 << n) + rs2 for n = 1, 2 and 3. Ops 9, 10 and 11 do the same after zero-extending rs1[31:0].
- R5: Op 12 returns {rs2[31:0], rs1[31:0]}. Op 13 returns {rs1[63:32], rs2[63:32]}. Op 14 returns rs2[7:0] in bits 15:8 and rs1[7:0] in bits 7:0, with all other bits zero.
- R6: Op 15 counts the leading zeros and op 16 counts the trailing zeros of rs1[31:0]. Both return 32 when that word is zero. Op 17 counts the set bits of rs1[31:0]. Each count is zero-extended.
- R7: Op 18 rotates rs1[31:0] left and op 19 rotates it right, by rs2[4:0]. The 32-bit result is sign-extended from bit 31.
- R8: Op 20 reverses the byte order of all 64 bits of rs1.
- R9: A result, and out_valid, appear on the clock edge after the one that samples in_valid high. When in_valid is low, out_valid falls and out_result holds its previous value.
- R10: Any op code from 21 to 31 produces a zero result. It also raises out_illegal together with out_valid. A legal op clears out_illegal.
- R11: While rst_n is low at a clock edge, out_valid, out_illegal and out_result all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 5 | Operation code |
| in_rs1 | input | 64 | First source operand |
| in_rs2 | input | 64 | Second source operand or shift amount |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Unsupported op code flag, with out_valid |

## Verification
Two things can land on the same clock edge: the result register loads a new operation, and it hands the previous result to the port. The bench provokes this by keeping the strobe high for its whole vector table, so that each edge both captures the next operation and presents the last one. Each sample is judged against a value worked out by hand for that vector. A second overlap occurs when an illegal code sits between legal ones. There the bench checks that the flag rises with a zero result and then clears on the very next legal result.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
// bm_pkg: operation codes shared by the bit-manipulation slice and its bench.
// Assumes a 5-bit op field; codes above OP_REV8 are unsupported.
package bm_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_BSET     = 5'd0,
        OP_BCLR     = 5'd1,
        OP_BINV     = 5'd2,
        OP_BEXT     = 5'd3,
        OP_SLO      = 5'd4,
        OP_SRO      = 5'd5,
        OP_SH1ADD   = 5'd6,
        OP_SH2ADD   = 5'd7,
        OP_SH3ADD   = 5'd8,
        OP_SH1ADDUW = 5'd9,
        OP_SH2ADDUW = 5'd10,
        OP_SH3ADDUW = 5'd11,
        OP_PACK     = 5'd12,
        OP_PACKU    = 5'd13,
        OP_PACKH    = 5'd14,
        OP_CLZW     = 5'd15,
        OP_CTZW     = 5'd16,
        OP_CPOPW    = 5'd17,
        OP_ROLW     = 5'd18,
        OP_RORW     = 5'd19,
        OP_REV8     = 5'd20
    } bm_op_e;

    // True when the code names an implemented operation.
    function automatic logic bm_op_legal(input logic [OP_W-1:0] code);
        return code <= OP_REV8;
    endfunction

endpackage

// File: rtl/bm_bit_ops.sv
`timescale 1ns/1ps
// bm_bit_ops: single-bit set/clear/invert/extract and shift-with-ones.
// Assumes XLEN is a power of two; the shift amount is the low log2(XLEN)
// bits of rs2. Outputs zero for any op outside this group.
module bm_bit_ops
    import bm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bm_op_e            op,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   rs2,
    output logic [XLEN-1:0]   res
);
    localparam int SH_W = $clog2(XLEN);

    logic [SH_W-1:0] shamt;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] shr_val;

    // Masked shift amount, one-hot bit mask and right-shifted operand.
    always_comb begin
        shamt   = rs2[SH_W-1:0];
        mask    = XLEN'(1) << shamt;
        shr_val = rs1 >> shamt;
    end

    // Select the result of this group.
    always_comb begin
        unique case (op)
            OP_BSET: res = rs1 | mask;
            OP_BCLR: res = rs1 & ~mask;
            OP_BINV: res = rs1 ^ mask;
            OP_BEXT: res = {{(XLEN-1){1'b0}}, shr_val[0]};
            OP_SLO:  res = ~((~rs1) << shamt);
            OP_SRO:  res = ~((~rs1) >> shamt);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bm_shadd_pack.sv
`timescale 1ns/1ps
// bm_shadd_pack: scaled add (plain and unsigned-word) and operand packing.
// Assumes XLEN >= 64 so that word and byte fields exist. Outputs zero for
// ops outside this group.
module bm_shadd_pack
    import bm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bm_op_e            op,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   rs2,
    output logic [XLEN-1:0]   res
);
    localparam int HALF   = XLEN / 2;
    localparam int SCALES = 3;

    logic [XLEN-1:0] rs1_uw;
    logic [XLEN-1:0] sum_full [1:SCALES];
    logic [XLEN-1:0] sum_uw   [1:SCALES];

    // Zero-extended low word of rs1 for the unsigned-word forms.
    always_comb rs1_uw = {{(XLEN-32){1'b0}}, rs1[31:0]};

    for (genvar g = 1; g <= SCALES; g++) begin : g_scale
        // One adder pair per scale factor.
        always_comb begin
            sum_full[g] = (rs1 << g) + rs2;
            sum_uw[g]   = (rs1_uw << g) + rs2;
        end
    end

    // Select the result of this group.
    always_comb begin
        unique case (op)
            OP_SH1ADD:   res = sum_full[1];
            OP_SH2ADD:   res = sum_full[2];
            OP_SH3ADD:   res = sum_full[3];
            OP_SH1ADDUW: res = sum_uw[1];
            OP_SH2ADDUW: res = sum_uw[2];
            OP_SH3ADDUW: res = sum_uw[3];
            OP_PACK:     res = {rs2[HALF-1:0], rs1[HALF-1:0]};
            OP_PACKU:    res = {rs1[XLEN-1:HALF], rs2[XLEN-1:HALF]};
            OP_PACKH:    res = {{(XLEN-16){1'b0}}, rs2[7:0], rs1[7:0]};
            default:     res = '0;
        endcase
    end
endmodule

// File: rtl/bm_word_ops.sv
`timescale 1ns/1ps
// bm_word_ops: 32-bit word counts (leading/trailing zeros, population) and
// word rotates. Counts run over the full register after the word is widened,
// so a zero word saturates at 32. Outputs zero for ops outside this group.
module bm_word_ops
    import bm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bm_op_e            op,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   rs2,
    output logic [XLEN-1:0]   res
);
    localparam int CNT_W = $clog2(XLEN) + 1;
    localparam int PAD   = XLEN - 32;

    // Leading-zero count over the full register width.
    function automatic logic [CNT_W-1:0] lead_zeros(input logic [XLEN-1:0] v);
        logic [CNT_W-1:0] n;
        logic             seen;
        n    = '0;
        seen = 1'b0;
        for (int i = XLEN-1; i >= 0; i--) begin
            if (v[i]) seen = 1'b1;
            else if (!seen) n = n + CNT_W'(1);
        end
        return n;
    endfunction

    // Trailing-zero count over the full register width.
    function automatic logic [CNT_W-1:0] trail_zeros(input logic [XLEN-1:0] v);
        logic [CNT_W-1:0] n;
        logic             seen;
        n    = '0;
        seen = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (v[i]) seen = 1'b1;
            else if (!seen) n = n + CNT_W'(1);
        end
        return n;
    endfunction

    logic [CNT_W-1:0] clz_cnt, ctz_cnt, pop_cnt;
    logic [63:0]      dbl, rol_d, ror_d;
    logic [31:0]      rol_w, ror_w;
    logic [4:0]       rot_amt;

    // Word counts: widen the word, count, then correct or saturate.
    always_comb begin
        clz_cnt = lead_zeros({{PAD{1'b0}}, rs1[31:0]}) - CNT_W'(PAD);
        ctz_cnt = trail_zeros({{PAD{1'b1}}, rs1[31:0]});
        pop_cnt = '0;
        for (int i = 0; i < 32; i++) pop_cnt = pop_cnt + CNT_W'(rs1[i]);
    end

    // Word rotates via a doubled copy of the low word.
    always_comb begin
        rot_amt = rs2[4:0];
        dbl     = {rs1[31:0], rs1[31:0]};
        rol_d   = dbl << rot_amt;
        ror_d   = dbl >> rot_amt;
        rol_w   = rol_d[63:32];
        ror_w   = ror_d[31:0];
    end

    // Select the result of this group.
    always_comb begin
        unique case (op)
            OP_CLZW:  res = {{(XLEN-CNT_W){1'b0}}, clz_cnt};
            OP_CTZW:  res = {{(XLEN-CNT_W){1'b0}}, ctz_cnt};
            OP_CPOPW: res = {{(XLEN-CNT_W){1'b0}}, pop_cnt};
            OP_ROLW:  res = {{PAD{rol_w[31]}}, rol_w};
            OP_RORW:  res = {{PAD{ror_w[31]}}, ror_w};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/bm_byte_rev.sv
`timescale 1ns/1ps
// bm_byte_rev: reverses the byte order of the full register.
// Assumes XLEN is a multiple of 8; pure wiring.
module bm_byte_rev #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout
);
    localparam int NBYTES = XLEN / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Byte b moves to the mirrored lane.
        assign dout[8*(NBYTES-1-b) +: 8] = din[8*b +: 8];
    end
endmodule

// File: rtl/bm_alu.sv
`timescale 1ns/1ps
// bm_alu: top of the bit-manipulation slice. Combines the operation groups,
// flags unsupported codes, and registers the result. Each group drives zero
// outside its own ops, so the groups are merged with an OR. The result
// register loads only on the strobe; valid and the illegal flag follow it
// by one cycle. Reset is synchronous and active low.
module bm_alu
    import bm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [4:0]         in_op,
    input  logic [XLEN-1:0]    in_rs1,
    input  logic [XLEN-1:0]    in_rs2,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic               out_illegal
);
    bm_op_e          op;
    logic            legal;
    logic [XLEN-1:0] r_bit, r_sp, r_word, r_rev, r_sel, r_next;

    // Interpret the op code and qualify it.
    always_comb begin
        op    = bm_op_e'(in_op);
        legal = bm_op_legal(in_op);
    end

    bm_bit_ops    #(.XLEN(XLEN)) u_bit  (.op(op), .rs1(in_rs1), .rs2(in_rs2), .res(r_bit));
    bm_shadd_pack #(.XLEN(XLEN)) u_sp   (.op(op), .rs1(in_rs1), .rs2(in_rs2), .res(r_sp));
    bm_word_ops   #(.XLEN(XLEN)) u_word (.op(op), .rs1(in_rs1), .rs2(in_rs2), .res(r_word));
    bm_byte_rev   #(.XLEN(XLEN)) u_rev  (.din(in_rs1), .dout(r_rev));

    // Merge group results; an unsupported code forces zero.
    always_comb begin
        r_sel  = r_bit | r_sp | r_word | ((op == OP_REV8) ? r_rev : '0);
        r_next = legal ? r_sel : '0;
    end

    logic            valid_q, illegal_q;
    logic [XLEN-1:0] result_q;

    // Output stage: result loads on strobe, flags track the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            result_q  <= '0;
        end else begin
            valid_q   <= in_valid;
            illegal_q <= in_valid & ~legal;
            if (in_valid) result_q <= r_next;
        end
    end

    assign out_valid   = valid_q;
    assign out_illegal = illegal_q;
    assign out_result  = result_q;
endmodule

// File: rtl/bm_alu_chk.sv
`timescale 1ns/1ps
// bm_alu_chk: temporal properties of the bit-manipulation slice's ports.
module bm_alu_chk
    import bm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      in_op,
    input logic [XLEN-1:0] in_rs1,
    input logic [XLEN-1:0] in_rs2,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_illegal
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_result)); // R9
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_illegal |-> (out_result == '0 && out_valid)); // R10
    AST_EXTRACT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_op == OP_BEXT) |=> (out_result <= XLEN'(1))); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_CLZW || in_op == OP_CTZW || in_op == OP_CPOPW)) |=> (out_result <= XLEN'(32))); // R6
endmodule

bind bm_alu bm_alu_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/bm_alu_tb_top.sv
`timescale 1ns/1ps
module bm_alu_tb_top;
    import bm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [63:0] in_rs1 = '0, in_rs2 = '0;
    logic        out_valid, out_illegal;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bm_alu #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  64'h0123_4567_89AB_CDEF, 64'h44, 64'h0123_4567_89AB_CDFF, 1'b0, 8'd1},  // R1 set, rs2 upper bits ignored
        '{5'd1,  64'h0123_4567_89AB_CDEF, 64'h0,  64'h0123_4567_89AB_CDEE, 1'b0, 8'd1},  // R1 clear
        '{5'd2,  64'h0123_4567_89AB_CDEF, 64'd63, 64'h8123_4567_89AB_CDEF, 1'b0, 8'd1},  // R1 invert top bit
        '{5'd3,  64'h0123_4567_89AB_CDEF, 64'd8,  64'h1,                   1'b0, 8'd2},  // R2 extract one
        '{5'd3,  64'h0123_4567_89AB_CDEF, 64'h49, 64'h0,                   1'b0, 8'd2},  // R2 extract zero, masked amount
        '{5'd4,  64'h0,                   64'd4,  64'hF,                   1'b0, 8'd3},  // R3 ones left
        '{5'd5,  64'h0,                   64'd60, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 8'd3},  // R3 ones right
        '{5'd6,  64'd5,                   64'd7,  64'h11,                  1'b0, 8'd4},  // R4 scale 1
        '{5'd7,  64'd5,                   64'd7,  64'h1B,                  1'b0, 8'd4},  // R4 scale 2
        '{5'd8,  64'd5,                   64'd7,  64'h2F,                  1'b0, 8'd4},  // R4 scale 3
        '{5'd9,  64'hFFFF_FFFF_8000_0001, 64'd1,  64'h1_0000_0003,         1'b0, 8'd4},  // R4 uw scale 1
        '{5'd10, 64'h1_0000_0001,         64'd0,  64'h4,                   1'b0, 8'd4},  // R4 uw scale 2
        '{5'd11, 64'hFFFF_FFFF_0000_0002, 64'd0,  64'h10,                  1'b0, 8'd4},  // R4 uw scale 3
        '{5'd12, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h7654_3210_89AB_CDEF, 1'b0, 8'd5}, // R5 pack
        '{5'd13, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0123_4567_FEDC_BA98, 1'b0, 8'd5}, // R5 pack upper
        '{5'd14, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h10EF, 1'b0, 8'd5},                 // R5 pack byte
        '{5'd21, 64'h0123_4567_89AB_CDEF, 64'h5,  64'h0,                   1'b1, 8'd10}, // R10 illegal code 21
        '{5'd15, 64'hFFFF_FFFF_0001_0000, 64'd0,  64'd15,                  1'b0, 8'd6},  // R6 clzw
        '{5'd15, 64'hFFFF_FFFF_0000_0000, 64'd0,  64'd32,                  1'b0, 8'd6},  // R6 clzw zero word
        '{5'd16, 64'h1_0000_0000,         64'd0,  64'd32,                  1'b0, 8'd6},  // R6 ctzw zero word
        '{5'd16, 64'h8,                   64'd0,  64'd3,                   1'b0, 8'd6},  // R6 ctzw
        '{5'd17, 64'hFFFF_FFFF_0000_00FF, 64'd0,  64'd8,                   1'b0, 8'd6},  // R6 cpopw
        '{5'd18, 64'h8000_0001,           64'h21, 64'h3,                   1'b0, 8'd7},  // R7 rolw, amount masked
        '{5'd19, 64'h1,                   64'd1,  64'hFFFF_FFFF_8000_0000, 1'b0, 8'd7},  // R7 rorw sign
        '{5'd18, 64'hABCD_1234,           64'd0,  64'hFFFF_FFFF_ABCD_1234, 1'b0, 8'd7},  // R7 rotate by zero
        '{5'd20, 64'h0123_4567_89AB_CDEF, 64'd0,  64'hEFCD_AB89_6745_2301, 1'b0, 8'd8},  // R8 byte reverse
        '{5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,  64'h0,                   1'b1, 8'd10}  // R10 illegal code 31
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid in reset", 64'(out_valid), 64'd0);
        chk("R11 result in reset", out_result, 64'd0);
        chk("R11 illegal in reset", 64'(out_illegal), 64'd0);
        rst_n = 1'b1;

        // Back-to-back walk: each edge loads a new op and presents the last.
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_op    = VECS[i].op;
            in_rs1   = VECS[i].a;
            in_rs2   = VECS[i].b;
            @(negedge clk);
            chk($sformatf("R%0d vec %0d result", VECS[i].req, i), out_result, VECS[i].exp);
            chk($sformatf("R%0d vec %0d illegal", VECS[i].req, i), 64'(out_illegal), 64'(VECS[i].ill));
            chk($sformatf("R9 vec %0d valid", i), 64'(out_valid), 64'd1);
        end

        // R9: strobe low -> valid falls, result holds despite new operands.
        held     = out_result;
        in_valid = 1'b0;
        in_op    = 5'd0;
        in_rs1   = 64'h0;
        in_rs2   = 64'd5;
        @(negedge clk);
        chk("R9 valid low", 64'(out_valid), 64'd0);
        chk("R9 result held", out_result, held);
        chk("R10 illegal cleared when idle", 64'(out_illegal), 64'd0);

        // R10: illegal then legal, flag clears on the legal result.
        in_valid = 1'b1; in_op = 5'd25; in_rs1 = 64'h55; in_rs2 = 64'h0;
        @(negedge clk);
        chk("R10 illegal flag", 64'(out_illegal), 64'd1);
        chk("R10 illegal result", out_result, 64'd0);
        in_op = 5'd0; in_rs1 = 64'h0; in_rs2 = 64'd63;
        @(negedge clk);
        chk("R10 legal clears flag", 64'(out_illegal), 64'd0);
        chk("R1 set top bit", out_result, 64'h8000_0000_0000_0000);

        // R11: reset clears a live result.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 result after reset", out_result, 64'd0);
        chk("R11 valid after reset", 64'(out_valid), 64'd0);
        in_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule